// File: doc/BRIEF.md
# Filter Coefficient and Control Register Load Sequencer

This block is the write side of a video filter's programming port. A host presents 12-bit words on a single bus, one per clock. A start strobe marks the first word of a transfer, and that word is taken as a target address. The data words that follow are gathered into one wide value. When the last word of the target has arrived, the block issues one write pulse to the register files outside it, together with the region code, the entry index, the bank select and the assembled value.

The top three bits of the address select one of eight regions. These are the coefficient banks, the configuration registers, and the horizontal and vertical select, round and limit registers. Each region expects a fixed number of data words, from one for a select value up to eight for a coefficient set. A hold input freezes the sequence for as many cycles as needed, so a host slower than the master clock can still feed the port.

Top module: `coef_load_seq`

## Requirements
- R1: After a synchronous active-low reset, `wr_en` is 0, `wr_data`, `wr_index`, `wr_region` and `wr_bank` are 0, and no transfer is in progress.
- R2: In a cycle where `ld_start` is 1 and `ld_hold` is 0, `ld_word` is taken as the address. Bits 11..9 give the region reported on `wr_region`: 0 coefficient bank, 1 configuration, 2 horizontal select, 3 vertical select, 4 horizontal round, 5 vertical round, 6 horizontal limit, 7 vertical limit.
- R3: After the address, the block accepts this many data words: 8 for a coefficient set, 1 for configuration, 1 for select, 3 for round, 2 for limit. `wr_en` is high for exactly one cycle, the cycle after the clock edge that accepts the last data word, and it stays low during the earlier words.
- R4: Data words are packed lowest word first, so word k lands at bits 12k+11..12k of `wr_data`. The result is cut to the field width and zero above it: 96 bits for a coefficient set, 12 for configuration, 5 for select, 32 for round, 24 for limit.
- R5: For regions 1 to 7, `wr_index` is address bits 3..0 with its upper bits 0, `wr_bank` is 0, and address bits 8..4 have no effect. For region 0, `wr_index` is address bits 7..0, and `wr_bank` is address bit 8 (0 horizontal, 1 vertical).
- R6: In a cycle where `ld_hold` is 1, the word is not accepted, `ld_start` is not sampled, and the sequence state is held. The transfer resumes unchanged when `ld_hold` returns to 0.
- R7: Words presented after a transfer has completed, without a new start strobe, are ignored. They produce no write pulse and leave all outputs unchanged.
- R8: A start strobe during an unfinished transfer abandons that transfer without a write pulse, and the word is taken as a new address.
- R9: `wr_data`, `wr_index`, `wr_region` and `wr_bank` keep their values from one write pulse to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ld_start | input | 1 | Marks the current word as an address |
| ld_hold | input | 1 | Freezes the load sequence while high |
| ld_word | input | 12 | Address or data word |
| wr_en | output | 1 | One-cycle write pulse |
| wr_region | output | 3 | Target region code |
| wr_bank | output | 1 | Coefficient bank: 0 horizontal, 1 vertical |
| wr_index | output | 8 | Entry index within the region |
| wr_data | output | 96 | Assembled value, zero above the field width |

## Verification
Every result of this block comes from a register loaded at the clock edge that accepts the last data word. The write pulse and the new output values are therefore visible one edge after that word is presented, and the pulse is gone one edge later. The bench drives each word on a falling edge and samples on the next falling edge, with exactly one rising edge in between. It checks that `wr_en` is low after each earlier word and high after the last one. It then checks that the pulse has dropped one cycle later, and that held, stray or abandoned words leave the outputs as they were.

// File: rtl/ldr_pkg.sv
// Shared types and helpers for the load sequencer.
// Assumes: region code is the top three bits of an address word.
package ldr_pkg;

    typedef enum logic [2:0] {
        RG_COEF = 3'd0,
        RG_CFG  = 3'd1,
        RG_HSEL = 3'd2,
        RG_VSEL = 3'd3,
        RG_HRND = 3'd4,
        RG_VRND = 3'd5,
        RG_HLIM = 3'd6,
        RG_VLIM = 3'd7
    } region_e;

    // Number of words needed to carry a field of the given width.
    function automatic int words_for(input int field_w, input int word_w);
        return (field_w + word_w - 1) / word_w;
    endfunction

endpackage

// File: rtl/ldr_region_decode.sv
// Decodes a captured address word into region, entry index, bank,
// data word count and field mask.
// Assumes: IDX_W < WORD_W - 3 so the bank bit sits below the region bits.
module ldr_region_decode
    import ldr_pkg::*;
#(
    parameter int WORD_W  = 12,
    parameter int IDX_W   = 8,
    parameter int ENT_W   = 4,
    parameter int CNT_W   = 4,
    parameter int DATA_W  = 96,
    parameter int SEL_W   = 5,
    parameter int ROUND_W = 32,
    parameter int LIMIT_W = 24
) (
    input  logic [WORD_W-1:0] addr,
    output region_e           region,
    output logic [IDX_W-1:0]  index,
    output logic              bank,
    output logic [CNT_W-1:0]  need,
    output logic [DATA_W-1:0] mask
);

    localparam int RG_LSB = WORD_W - 3;

    int field_w;

    // Region, index and bank from the address fields.
    always_comb begin
        region = region_e'(addr[WORD_W-1:RG_LSB]);
        if (region == RG_COEF) begin
            index = addr[IDX_W-1:0];
            bank  = addr[IDX_W];
        end else begin
            index = '0;
            index[ENT_W-1:0] = addr[ENT_W-1:0];
            bank  = 1'b0;
        end
    end

    // Field width of the target and the word count it implies.
    always_comb begin
        case (region)
            RG_COEF:          field_w = DATA_W;
            RG_CFG:           field_w = WORD_W;
            RG_HSEL, RG_VSEL: field_w = SEL_W;
            RG_HRND, RG_VRND: field_w = ROUND_W;
            default:          field_w = LIMIT_W;
        endcase
        need = CNT_W'(words_for(field_w, WORD_W));
        mask = {DATA_W{1'b1}} >> (DATA_W - field_w);
    end

endmodule

// File: rtl/ldr_sequencer.sv
// Address-then-data sequencer with pause and restart.
// Assumes: need >= 1 and is stable while a transfer is in progress.
module ldr_sequencer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             hold,
    input  logic [CNT_W-1:0] need,
    output logic             cap,
    output logic             take,
    output logic             last,
    output logic [CNT_W-1:0] slot,
    output logic             done
);

    logic             busy;
    logic [CNT_W-1:0] cnt;

    // Qualify the word on the bus as address, data or nothing.
    always_comb begin
        cap  = start && !hold;
        take = busy && !hold && !start;
        last = take && (cnt == need - 1'b1);
        slot = cnt;
    end

    // Track transfer progress and raise the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
            done <= 1'b0;
        end else begin
            done <= last;
            if (cap) begin
                busy <= 1'b1;
                cnt  <= '0;
            end else if (last) begin
                busy <= 1'b0;
                cnt  <= '0;
            end else if (take) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    p_pause_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> ($stable(busy) && $stable(cnt)));

    p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_count_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt < need));

    p_restart_no_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> !done);

endmodule

// File: rtl/ldr_assemble.sv
// Collects data words into slots, lowest word first, and registers the
// masked value when the last word arrives.
// Assumes: slot < NSLOT whenever take is high.
module ldr_assemble #(
    parameter int WORD_W = 12,
    parameter int NSLOT  = 8,
    parameter int CNT_W  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      take,
    input  logic                      last,
    input  logic [CNT_W-1:0]          slot,
    input  logic [WORD_W-1:0]         word,
    input  logic [NSLOT*WORD_W-1:0]   mask,
    output logic [NSLOT*WORD_W-1:0]   data
);

    localparam int DATA_W = NSLOT * WORD_W;

    logic [DATA_W-1:0] merged;

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        logic [WORD_W-1:0] slot_q;
        logic              hit;

        assign hit = take && (slot == CNT_W'(i));

        // Store the word aimed at this slot.
        always_ff @(posedge clk) begin
            if (!rst_n) slot_q <= '0;
            else if (hit) slot_q <= word;
        end

        assign merged[i*WORD_W +: WORD_W] = hit ? word : slot_q;
    end

    // Register the masked value at the end of a transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) data <= '0;
        else if (last) data <= merged & mask;
    end

    p_data_in_field_r4: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> ((data & ~$past(mask)) == '0));

endmodule

// File: rtl/coef_load_seq.sv
// Top of the load sequencer: captures the address, decodes it, gathers the
// data words and presents one write pulse per completed transfer.
// Assumes: register files sample wr_* while wr_en is high.
module coef_load_seq
    import ldr_pkg::*;
#(
    parameter int WORD_W    = 12,
    parameter int COEF_SETS = 256,
    parameter int ENTRIES   = 16,
    parameter int TAPS      = 8,
    parameter int SEL_W     = 5,
    parameter int ROUND_W   = 32,
    parameter int LIMIT_W   = 24,
    localparam int IDX_W    = $clog2(COEF_SETS),
    localparam int DATA_W   = WORD_W * TAPS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_start,
    input  logic              ld_hold,
    input  logic [WORD_W-1:0] ld_word,
    output logic              wr_en,
    output logic [2:0]        wr_region,
    output logic              wr_bank,
    output logic [IDX_W-1:0]  wr_index,
    output logic [DATA_W-1:0] wr_data
);

    localparam int ENT_W = $clog2(ENTRIES);
    localparam int CNT_W = $clog2(TAPS + 1);

    logic [WORD_W-1:0] addr_q;
    region_e           region;
    logic [IDX_W-1:0]  index;
    logic              bank;
    logic [CNT_W-1:0]  need;
    logic [DATA_W-1:0] mask;
    logic              cap, take, last, done;
    logic [CNT_W-1:0]  slot;

    // Hold the address word of the current transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) addr_q <= '0;
        else if (cap) addr_q <= ld_word;
    end

    ldr_region_decode #(
        .WORD_W (WORD_W), .IDX_W (IDX_W), .ENT_W (ENT_W), .CNT_W (CNT_W),
        .DATA_W (DATA_W), .SEL_W (SEL_W), .ROUND_W (ROUND_W), .LIMIT_W (LIMIT_W)
    ) u_dec (
        .addr (addr_q), .region (region), .index (index), .bank (bank),
        .need (need), .mask (mask)
    );

    ldr_sequencer #(.CNT_W (CNT_W)) u_seq (
        .clk (clk), .rst_n (rst_n), .start (ld_start), .hold (ld_hold),
        .need (need), .cap (cap), .take (take), .last (last),
        .slot (slot), .done (done)
    );

    ldr_assemble #(.WORD_W (WORD_W), .NSLOT (TAPS), .CNT_W (CNT_W)) u_asm (
        .clk (clk), .rst_n (rst_n), .take (take), .last (last),
        .slot (slot), .word (ld_word), .mask (mask), .data (wr_data)
    );

    // Latch the target description alongside the data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_region <= '0;
            wr_bank   <= 1'b0;
            wr_index  <= '0;
        end else if (last) begin
            wr_region <= region;
            wr_bank   <= bank;
            wr_index  <= index;
        end
    end

    assign wr_en = done;

    p_narrow_index_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_region != 3'd0) |-> (wr_index[IDX_W-1:ENT_W] == '0 && !wr_bank));

    p_outputs_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> ($stable(wr_data) && $stable(wr_index) && $stable(wr_region)));

    p_pause_no_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ld_hold |=> !wr_en);

endmodule

// File: tb/sim_coef_load_seq.sv
module sim_coef_load_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_start = 1'b0;
    logic        ld_hold = 1'b0;
    logic [11:0] ld_word = '0;
    logic        wr_en;
    logic [2:0]  wr_region;
    logic        wr_bank;
    logic [7:0]  wr_index;
    logic [95:0] wr_data;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    coef_load_seq u0 (
        .clk (clk), .rst_n (rst_n), .ld_start (ld_start), .ld_hold (ld_hold),
        .ld_word (ld_word), .wr_en (wr_en), .wr_region (wr_region),
        .wr_bank (wr_bank), .wr_index (wr_index), .wr_data (wr_data)
    );

    task automatic chk(input string req, input logic [95:0] act, input logic [95:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one word on a falling edge; return at the next falling edge.
    task automatic put(input logic [11:0] w, input logic s, input logic h);
        ld_word = w; ld_start = s; ld_hold = h;
        @(negedge clk);
    endtask

    task automatic chk_target(input string req, input logic [2:0] rg,
                              input logic bk, input logic [7:0] ix, input logic [95:0] d);
        chk({req, " wr_en"}, 96'(wr_en), 96'd1);
        chk({req, " region"}, 96'(wr_region), 96'(rg));
        chk({req, " bank"}, 96'(wr_bank), 96'(bk));
        chk({req, " index"}, 96'(wr_index), 96'(ix));
        chk({req, " data"}, wr_data, d);
    endtask

    task automatic t_reset();
        chk("R1 wr_en", 96'(wr_en), 96'd0);
        chk("R1 data", wr_data, 96'd0);
        chk("R1 index", 96'(wr_index), 96'd0);
        chk("R1 region", 96'(wr_region), 96'd0);
    endtask

    task automatic t_round();
        put(12'h805, 1, 0);
        put(12'h123, 0, 0);
        put(12'h456, 0, 0);
        chk("R3 early round", 96'(wr_en), 96'd0);
        put(12'h789, 0, 0);
        chk_target("R2 R4 round", 3'd4, 0, 8'h05, 96'h89456123);
        put(12'h000, 0, 0);
        chk("R3 pulse width", 96'(wr_en), 96'd0);
    endtask

    task automatic t_limit();
        put(12'hFFF, 1, 0);
        put(12'hABC, 0, 0);
        chk("R3 early limit", 96'(wr_en), 96'd0);
        put(12'hDEF, 0, 0);
        chk_target("R5 limit", 3'd7, 0, 8'h0F, 96'hDEFABC);
        put(12'h000, 0, 0);
    endtask

    task automatic t_select_cfg();
        put(12'h5FA, 1, 0);
        put(12'hFFF, 0, 0);
        chk_target("R4 select", 3'd2, 0, 8'h0A, 96'h1F);
        put(12'h3F3, 1, 0);
        put(12'hA5C, 0, 0);
        chk_target("R4 config", 3'd1, 0, 8'h03, 96'hA5C);
    endtask

    task automatic t_coef();
        logic [95:0] exp = '0;
        put(12'h137, 1, 0);
        for (int k = 0; k < 8; k++) begin
            exp[k*12 +: 12] = 12'(k * 12'h111 + 1);
            if (k == 7) chk("R3 early coef", 96'(wr_en), 96'd0);
            put(12'(k * 12'h111 + 1), 0, 0);
        end
        chk_target("R5 coef bank", 3'd0, 1, 8'h37, exp);
        put(12'h000, 0, 0);
    endtask

    task automatic t_pause();
        put(12'h0AA, 1, 1);
        put(12'hA03, 1, 0);
        put(12'h111, 0, 1);
        put(12'h001, 0, 0);
        put(12'hEEE, 1, 1);
        put(12'hDDD, 0, 1);
        put(12'h002, 0, 0);
        put(12'hCCC, 0, 1);
        chk("R6 no pulse while held", 96'(wr_en), 96'd0);
        put(12'h003, 0, 0);
        chk_target("R6 pause", 3'd5, 0, 8'h03, 96'h003002001);
    endtask

    task automatic t_ignore();
        logic [95:0] d = wr_data;
        for (int k = 0; k < 5; k++) begin
            put(12'(12'h700 + k), 0, 0);
            chk("R7 no pulse", 96'(wr_en), 96'd0);
        end
        chk("R9 data held", wr_data, d);
        chk("R9 index held", 96'(wr_index), 96'h03);
    endtask

    task automatic t_restart();
        put(12'h801, 1, 0);
        put(12'h444, 0, 0);
        put(12'h20C, 1, 0);
        chk("R8 no pulse on restart", 96'(wr_en), 96'd0);
        put(12'h5A5, 0, 0);
        chk_target("R8 restart", 3'd1, 0, 8'h0C, 96'h5A5);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_round();
        t_limit();
        t_select_cfg();
        t_coef();
        t_pause();
        t_ignore();
        t_restart();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule